// File: doc/BRIEF.md
# Memory Test Path Router

This block sits between one memory self-test controller and several embedded memories. The controller gives a slot code on every cycle. The block routes the controller's request to the memory in that slot: a request valid, the write enable, the test-mode enable, the address and the write data. It then carries the read data from that memory back to the controller. Memories sit at different physical distances from the controller. Because of this, every slot has its own number of register stages on the way out and its own number on the way back, and the two numbers are set separately at compile time. A depth of zero means a plain wire. The memory arrays are outside the block. Each one answers a read a fixed number of cycles (`MEM_LAT`) after it sees the read request.

Only reads produce a response. For each read, the slot that served it carries a flag back alongside the data. The flag shows up on the response port exactly `FWD_LAT[i] + MEM_LAT + RET_LAT[i]` cycles after the request was accepted. The request side is valid-only and is accepted on every cycle. The response side has no ready input and cannot be stalled, so the controller must take each response in the cycle it appears. When the controller moves to a slot with a shorter total latency, it must first wait until the old slot has drained. Otherwise two slots could present a response or a request in the same cycle.

Top module: `mbr_router`

## Requirements
- R1: While reset is low and in the first cycle after it, every memory-side output and both response outputs are zero.
- R2: A request with `req_sel == i` (i < NUM_MEM) appears on slot i's memory pins exactly `FWD_LAT[i]` cycles later, with `mem_vld[i]=1` and the same write enable, address and write data. `mem_tm[i]` follows `req_tm` with the same delay whenever slot i was selected, with or without a request.
- R3: A slot whose delayed select does not match, or that has no request in flight, shows zero on valid, write enable, address and write data. Its test-mode pin is zero unless it was selected.
- R4: A read (`req_vld=1`, `req_we=0`) to slot i raises `rsp_vld` exactly `FWD_LAT[i] + MEM_LAT + RET_LAT[i]` cycles later. `rsp_data` then holds the word the memory returned for that address.
- R5: A write (`req_we=1`) reaches the memory but never raises `rsp_vld`.
- R6: A select code of `NUM_MEM` or above drives no slot and produces no response.
- R7: `rsp_data` is zero in every cycle where `rsp_vld` is low.
- R8: Slots have independent latencies: slot 0 is combinational on the forward path (depth 0), and the defaults give total round trips of 2, 3, 5 and 6 cycles for slots 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request present this cycle |
| req_sel | input | SEL_W | Slot code choosing the memory |
| req_we | input | 1 | Write (1) or read (0) |
| req_tm | input | 1 | Test-mode enable for the selected memory |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_vld | output | 1 | Read data present this cycle |
| rsp_data | output | DATA_W | Read data, zero when not valid |
| mem_vld | output | NUM_MEM | Per-slot access strobe |
| mem_we | output | NUM_MEM | Per-slot write enable |
| mem_tm | output | NUM_MEM | Per-slot test-mode enable |
| mem_addr | output | NUM_MEM*ADDR_W | Per-slot address, slot i at bits i*ADDR_W |
| mem_wdata | output | NUM_MEM*DATA_W | Per-slot write data, slot i at bits i*DATA_W |
| mem_rdata | input | NUM_MEM*DATA_W | Per-slot read data from the memories |

## Verification
The stimulus starts with directed write-then-read pairs to every slot and to an out-of-range code. These show whether each slot's own forward and return depth is applied, rather than a shared one, and whether a code with no slot stays silent. Random bursts follow. Each burst stays on one slot and mixes reads, writes, idle cycles and test-mode toggles, with drain gaps between bursts. They show whether write data lands at the right address and whether idle slots stay quiet while a neighbour is busy. They also show whether the test-mode pin is tied to the select rather than to the request valid.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  // latency values for the per-slot register chains
  typedef int unsigned lat_t;

  // round trip from request acceptance to response
  function automatic lat_t round_trip(lat_t fwd, lat_t mem, lat_t ret);
    return fwd + mem + ret;
  endfunction
endpackage

// File: rtl/mbr_pipe.sv
// Reset-to-zero shift chain, DEPTH >= 1.
module mbr_pipe #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < DEPTH; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/mbr_slot.sv
// One memory slot: forward chain, read-tag delay across the memory, return chain.
module mbr_slot #(
  parameter int unsigned          SLOT_ID = 0,
  parameter int unsigned          SEL_W   = 3,
  parameter int unsigned          ADDR_W  = 6,
  parameter int unsigned          DATA_W  = 16,
  parameter mbr_pkg::lat_t        FWD     = 0,
  parameter mbr_pkg::lat_t        MEM_LAT = 1,
  parameter mbr_pkg::lat_t        RET     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic              req_vld,
  input  logic              req_we,
  input  logic              req_tm,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_vld,
  output logic              mem_we,
  output logic              mem_tm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ret_vld,
  output logic [DATA_W-1:0] ret_data
);
  localparam int unsigned FW = 3 + ADDR_W + DATA_W;
  localparam int unsigned RW = 1 + DATA_W;

  logic          hit, go;
  logic [FW-1:0] fwd_d, fwd_q;
  logic          tag_d, tag_q;
  logic [RW-1:0] ret_d, ret_q;

  assign hit = (req_sel == SEL_W'(SLOT_ID));
  assign go  = hit & req_vld;

  always_comb begin
    fwd_d = '0;
    fwd_d[FW-1] = go;
    fwd_d[FW-2] = go & req_we;
    fwd_d[FW-3] = hit & req_tm;
    if (go) begin
      fwd_d[ADDR_W+DATA_W-1:DATA_W] = req_addr;
      fwd_d[DATA_W-1:0]             = req_wdata;
    end
  end

  generate
    if (FWD == 0) begin : g_fwd_wire
      assign fwd_q = fwd_d;
    end else begin : g_fwd_reg
      mbr_pipe #(.WIDTH(FW), .DEPTH(FWD)) u_fwd (
        .clk(clk), .rst_n(rst_n), .d(fwd_d), .q(fwd_q));
    end
  endgenerate

  assign mem_vld   = fwd_q[FW-1];
  assign mem_we    = fwd_q[FW-2];
  assign mem_tm    = fwd_q[FW-3];
  assign mem_addr  = fwd_q[ADDR_W+DATA_W-1:DATA_W];
  assign mem_wdata = fwd_q[DATA_W-1:0];

  // a read leaves a tag that meets the memory's answer
  assign tag_d = mem_vld & ~mem_we;

  generate
    if (MEM_LAT == 0) begin : g_tag_wire
      assign tag_q = tag_d;
    end else begin : g_tag_reg
      mbr_pipe #(.WIDTH(1), .DEPTH(MEM_LAT)) u_tag (
        .clk(clk), .rst_n(rst_n), .d(tag_d), .q(tag_q));
    end
  endgenerate

  assign ret_d = {tag_q, (tag_q ? mem_rdata : {DATA_W{1'b0}})};

  generate
    if (RET == 0) begin : g_ret_wire
      assign ret_q = ret_d;
    end else begin : g_ret_reg
      mbr_pipe #(.WIDTH(RW), .DEPTH(RET)) u_ret (
        .clk(clk), .rst_n(rst_n), .d(ret_d), .q(ret_q));
    end
  endgenerate

  assign ret_vld  = ret_q[RW-1];
  assign ret_data = ret_q[DATA_W-1:0];
endmodule

// File: rtl/mbr_merge.sv
// Combines slot returns; each slot already zeroes its data when idle.
module mbr_merge #(
  parameter int unsigned NUM_MEM = 4,
  parameter int unsigned DATA_W  = 16
) (
  input  logic [NUM_MEM-1:0]        ret_vld,
  input  logic [NUM_MEM*DATA_W-1:0] ret_data,
  output logic                      rsp_vld,
  output logic [DATA_W-1:0]         rsp_data
);
  always_comb begin
    rsp_vld  = 1'b0;
    rsp_data = '0;
    for (int i = 0; i < NUM_MEM; i++) begin
      rsp_vld  = rsp_vld | ret_vld[i];
      rsp_data = rsp_data | ret_data[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/mbr_router.sv
module mbr_router #(
  parameter int unsigned   NUM_MEM = 4,
  parameter int unsigned   SEL_W   = 3,
  parameter int unsigned   ADDR_W  = 6,
  parameter int unsigned   DATA_W  = 16,
  parameter mbr_pkg::lat_t MEM_LAT = 1,
  parameter mbr_pkg::lat_t FWD_LAT [NUM_MEM] = '{0, 2, 1, 3},
  parameter mbr_pkg::lat_t RET_LAT [NUM_MEM] = '{1, 0, 3, 2}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_vld,
  input  logic [SEL_W-1:0]          req_sel,
  input  logic                      req_we,
  input  logic                      req_tm,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rsp_vld,
  output logic [DATA_W-1:0]         rsp_data,
  output logic [NUM_MEM-1:0]        mem_vld,
  output logic [NUM_MEM-1:0]        mem_we,
  output logic [NUM_MEM-1:0]        mem_tm,
  output logic [NUM_MEM*ADDR_W-1:0] mem_addr,
  output logic [NUM_MEM*DATA_W-1:0] mem_wdata,
  input  logic [NUM_MEM*DATA_W-1:0] mem_rdata
);
  logic [NUM_MEM-1:0]        ret_vld;
  logic [NUM_MEM*DATA_W-1:0] ret_data;

  generate
    for (genvar g = 0; g < NUM_MEM; g++) begin : g_slot
      mbr_slot #(
        .SLOT_ID(g), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FWD(FWD_LAT[g]), .MEM_LAT(MEM_LAT), .RET(RET_LAT[g])
      ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_sel   (req_sel),
        .req_vld   (req_vld),
        .req_we    (req_we),
        .req_tm    (req_tm),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_vld   (mem_vld[g]),
        .mem_we    (mem_we[g]),
        .mem_tm    (mem_tm[g]),
        .mem_addr  (mem_addr[g*ADDR_W +: ADDR_W]),
        .mem_wdata (mem_wdata[g*DATA_W +: DATA_W]),
        .mem_rdata (mem_rdata[g*DATA_W +: DATA_W]),
        .ret_vld   (ret_vld[g]),
        .ret_data  (ret_data[g*DATA_W +: DATA_W])
      );
    end
  endgenerate

  mbr_merge #(.NUM_MEM(NUM_MEM), .DATA_W(DATA_W)) u_merge (
    .ret_vld  (ret_vld),
    .ret_data (ret_data),
    .rsp_vld  (rsp_vld),
    .rsp_data (rsp_data)
  );
endmodule

// File: rtl/mbr_router_chk.sv
module mbr_router_chk #(
  parameter int unsigned   NUM_MEM = 4,
  parameter int unsigned   SEL_W   = 3,
  parameter int unsigned   ADDR_W  = 6,
  parameter int unsigned   DATA_W  = 16,
  parameter mbr_pkg::lat_t FWD_LAT [NUM_MEM] = '{0, 2, 1, 3}
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_vld,
  input logic [SEL_W-1:0]          req_sel,
  input logic                      req_we,
  input logic [ADDR_W-1:0]         req_addr,
  input logic                      rsp_vld,
  input logic [DATA_W-1:0]         rsp_data,
  input logic [NUM_MEM-1:0]        mem_vld,
  input logic [NUM_MEM-1:0]        mem_we,
  input logic [NUM_MEM*ADDR_W-1:0] mem_addr,
  input logic [NUM_MEM*DATA_W-1:0] mem_wdata
);
  // R7
  rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (rsp_data == '0));

  generate
    for (genvar g = 0; g < NUM_MEM; g++) begin : g_c
      // R3
      idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_vld[g] |-> (!mem_we[g] && mem_addr[g*ADDR_W +: ADDR_W] == '0
                         && mem_wdata[g*DATA_W +: DATA_W] == '0));
      if (FWD_LAT[g] == 0) begin : g_f0
        // R2
        fwd_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (req_vld && req_sel == SEL_W'(g)) |->
            (mem_vld[g] && mem_we[g] == req_we
             && mem_addr[g*ADDR_W +: ADDR_W] == req_addr));
      end else if (FWD_LAT[g] == 1) begin : g_f1
        // R2
        fwd_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (req_vld && req_sel == SEL_W'(g)) |=>
            (mem_vld[g] && mem_we[g] == $past(req_we)
             && mem_addr[g*ADDR_W +: ADDR_W] == $past(req_addr)));
      end
    end
  endgenerate
endmodule

bind mbr_router mbr_router_chk #(
  .NUM_MEM(NUM_MEM), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .FWD_LAT(FWD_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_sel(req_sel),
  .req_we(req_we), .req_addr(req_addr), .rsp_vld(rsp_vld),
  .rsp_data(rsp_data), .mem_vld(mem_vld), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/sim_mbr_router.sv
`timescale 1ns/1ps
module sim_mbr_router;
  localparam int NM = 4, SW = 3, AW = 6, DW = 16, ML = 1;
  localparam int F [NM] = '{0, 2, 1, 3};
  localparam int R [NM] = '{1, 0, 3, 2};
  localparam int HN = 256;

  logic clk = 0, rst_n = 0;
  logic req_vld = 0, req_we = 0, req_tm = 0;
  logic [SW-1:0] req_sel = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic rsp_vld;
  logic [DW-1:0] rsp_data;
  logic [NM-1:0] mem_vld, mem_we, mem_tm;
  logic [NM*AW-1:0] mem_addr;
  logic [NM*DW-1:0] mem_wdata;
  logic [NM*DW-1:0] mem_rdata = '0;

  always #10 clk = ~clk;

  mbr_router u0 (.*);

  // memory models, one-cycle read
  logic [DW-1:0] marr [NM][64];
  always @(posedge clk) begin
    for (int j = 0; j < NM; j++) begin
      if (mem_vld[j] && mem_we[j]) marr[j][mem_addr[j*AW +: AW]] <= mem_wdata[j*DW +: DW];
      if (mem_vld[j] && !mem_we[j]) mem_rdata[j*DW +: DW] <= marr[j][mem_addr[j*AW +: AW]];
    end
  end

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [DW-1:0] shadow [NM][64];
  int h_sel [HN]; bit h_vld [HN], h_we [HN], h_tm [HN];
  int h_addr [HN], h_wd [HN];
  bit ex_v [HN]; int ex_d [HN];

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%0h exp=%0h", req, cyc, act, exp);
    end
  endtask

  // one clock cycle: drive, record, predict, check
  task automatic step(int sel, bit vld, bit we, bit tm, int addr, int wd);
    int k, lat;
    @(negedge clk);
    cyc++;
    req_sel = SW'(sel); req_vld = vld; req_we = we; req_tm = tm;
    req_addr = AW'(addr); req_wdata = DW'(wd);
    k = cyc % HN;
    h_sel[k] = sel; h_vld[k] = vld; h_we[k] = we; h_tm[k] = tm;
    h_addr[k] = addr; h_wd[k] = wd;
    if (vld && sel < NM) begin
      if (we) shadow[sel][addr] = DW'(wd);
      else begin
        lat = F[sel] + ML + R[sel];
        ex_v[(cyc + lat) % HN] = 1;
        ex_d[(cyc + lat) % HN] = int'(shadow[sel][addr]);
      end
    end
    #1;
    for (int j = 0; j < NM; j++) begin
      int kk; bit ev, etm;
      kk = (cyc - F[j] + HN) % HN;
      ev  = h_vld[kk] && h_sel[kk] == j;
      etm = h_tm[kk] && h_sel[kk] == j;
      // R2 R3 R6 R8: forward pins of slot j after its own depth
      chk("R2/R3/R6 fwd", {mem_vld[j], mem_we[j], mem_tm[j]},
          {ev, ev && h_we[kk], etm});
      chk("R2/R3 addr", int'(mem_addr[j*AW +: AW]), ev ? h_addr[kk] : 0);
      chk("R2/R3 wdata", int'(mem_wdata[j*DW +: DW]), ev ? h_wd[kk] : 0);
    end
    // R4 R5 R6 R7: response timing and data
    chk("R4/R5/R6 rsp_vld", int'(rsp_vld), int'(ex_v[k]));
    chk("R4/R7 rsp_data", int'(rsp_data), ex_v[k] ? ex_d[k] : 0);
    ex_v[k] = 0;
  endtask

  task automatic idle(int sel, int n);
    for (int i = 0; i < n; i++) step(sel, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int j = 0; j < NM; j++)
      for (int a = 0; a < 64; a++) begin marr[j][a] = '0; shadow[j][a] = '0; end
    for (int i = 0; i < HN; i++) begin
      h_sel[i] = 0; h_vld[i] = 0; h_we[i] = 0; h_tm[i] = 0;
      h_addr[i] = 0; h_wd[i] = 0; ex_v[i] = 0; ex_d[i] = 0;
    end
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mem_vld", int'(mem_vld), 0);
    chk("R1 mem_tm", int'(mem_tm), 0);
    chk("R1 rsp", int'({rsp_vld, rsp_data}), 0);
    rst_n = 1;
    idle(0, 1);
    // R8: write then read each slot, latencies 2,3,5,6
    for (int s = 0; s < NM; s++) begin
      step(s, 1, 1, 1, 5 + s, 16'hA000 + s);
      step(s, 1, 0, 1, 5 + s, 0);
      idle(s, 8);
    end
    // R6: out-of-range codes
    step(5, 1, 1, 1, 7, 16'hBEEF);
    step(4, 1, 0, 1, 7, 0);
    step(7, 1, 0, 0, 7, 0);
    idle(7, 8);
    // R5: writes alone give no response
    for (int i = 0; i < 6; i++) step(2, 1, 1, 0, i, 16'h1111 * i);
    idle(2, 8);
    // random bursts
    for (int b = 0; b < 60; b++) begin
      int sel, len;
      sel = $urandom % 6;
      len = 1 + $urandom % 12;
      for (int i = 0; i < len; i++)
        step(sel, ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
             $urandom % 64, $urandom % 65536);
      idle(sel, 8);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule